// File: doc/BRIEF.md
# Extended fault signature classifier

This block sits behind a march-test sequencer and turns its stream of failing-read reports into a diagnosis. Each report carries four things: which of the five reads of the march run failed, the address that was read, and the addresses accessed just before and just after it in the addressing order. The block keeps a 5-bit read syndrome for the whole run. It also records two 2-bit relation fields that describe how the two neighbouring accesses sit relative to the failing cell. One bit says whether the neighbour uses the same I/O circuit, and the other says whether it lies in the same column. Together these form a 9-bit extended signature.

When the sequencer signals the end of the run, the block checks the signature against a fixed rule set. It then reports a 3-bit class. The class tells whether the failures look purely static, whether an un-restored write fault can have been sensitized, and which element is then to blame: the write driver, the precharge circuit, or either one. It can also report that the result is ambiguous between a static coupling fault and a dynamic fault. A write-driver fault needs a write and a following opposite-value read on two different cells that share one I/O circuit. A precharge fault needs the same sequence on two different cells that share one column.

Top module: `ext_sig_classifier`

## Requirements
- R1: After reset, `signature`, `class_code` and `class_valid` are all zero.
- R2: The column is the low `COL_W` bits of an address. A relation field is {same I/O, same column}. Same I/O means the top column bits of the two addresses are equal. Same column means all column bits are equal. The value 01 never appears.
- R3: A failing read with index i in 0..4 sets `signature[8-i]` in the next cycle (R0 is bit 8, R4 is bit 4). Set bits stay set until the next `test_start`. Indexes 5 to 7 have no effect.
- R4: The previous-address relation sits in `signature[3:2]` and the next-address relation in `signature[1:0]`. Both are taken from the first accepted failing read after `test_start`. Later failing reads leave them unchanged. They stay 00 while nothing has failed.
- R5: `test_start` clears the signature in the next cycle. A failing read in the same cycle as `test_start` is dropped.
- R6: `class_valid` is high for exactly the one cycle after each `test_done`. `class_code` takes its new value in that same cycle and holds it until the next `test_done`. A failing read in the same cycle as `test_done` is included in the classification.
- R7: Class codes are: none = 0, static-only = 1, write driver = 2, precharge = 3, either element = 4, ambiguous = 5. A zero syndrome gives none. Syndromes 01010, 10101 and 00101 (written R0..R4) give static-only whatever the relation fields.
- R8: Any other non-zero syndrome gives static-only when both relation fields are 00.
- R9: Syndrome 10000 with at least one relation field not equal to 00 gives ambiguous.
- R10: For the remaining syndromes, the class depends on the relation fields. If at least one field is 10 and none is 11, the class is write driver. If at least one field is 11 and none is 10, the class is either element.
- R11: For the remaining syndromes with one field 10 and the other 11, the class depends on which reads failed. Reads R0, R1 and R4 are steered by the previous-address field, and reads R2 and R3 by the next-address field. The class is precharge if every failing read belongs to the group steered by the 11 field. Otherwise it is write driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_start | input | 1 | Pulse that opens a new march run and clears the signature |
| fail_valid | input | 1 | A failing read is reported this cycle |
| fail_read_idx | input | 3 | Index of the failing read in the march run (0..4) |
| cur_addr | input | ADDR_W | Address of the failing read |
| prev_addr | input | ADDR_W | Address accessed just before it |
| next_addr | input | ADDR_W | Address accessed just after it |
| test_done | input | 1 | Pulse marking the end of the run |
| signature | output | 9 | Extended signature: syndrome R0..R4, previous field, next field |
| class_code | output | 3 | Classification result |
| class_valid | output | 1 | One-cycle pulse after `test_done` |

## Verification
The bench sweeps every 5-bit syndrome against every reachable pair of relation fields and predicts the class from the rule list. A rule evaluated in the wrong order would show up at once. So would swapped group masks in the mixed case, or a design that treats 11 as write-driver evidence. The extra failing reads in each run carry different relations, so a design that re-latches the fields on every failure would report the wrong fields. Directed cases cover several situations. Out-of-range read indexes must leave the signature empty. A failure arriving together with `test_start` must be dropped. A failure arriving together with `test_done` must still count, so a design that classified from the registered syndrome would miss it. The class must also be held after the valid pulse ends.

// File: rtl/ext_sig_pkg.sv
// Package: shared constants, class codes and static reference syndromes for
// the extended fault signature classifier. Syndromes are written R0 at MSB.
package ext_sig_pkg;

    localparam int NREAD   = 5;                  // reads in the march run
    localparam int IDX_W   = 3;                  // width of the read index
    localparam int FIELD_W = 2;                  // {same I/O, same column}
    localparam int SIG_W   = NREAD + 2*FIELD_W;  // full signature width

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_STATIC = 3'd1,
        CLS_WDRV   = 3'd2,
        CLS_PRECH  = 3'd3,
        CLS_EITHER = 3'd4,
        CLS_AMBIG  = 3'd5
    } class_e;

    // Reads whose predecessor in time is the previous address (R0,R1,R4)
    localparam logic [NREAD-1:0] PREV_GROUP = 5'b11001;
    // Reads whose predecessor in time is the next address (R2,R3)
    localparam logic [NREAD-1:0] NEXT_GROUP = 5'b00110;
    // Syndrome shared by a static coupling fault and an un-restored write
    localparam logic [NREAD-1:0] SHARED_SYN = 5'b10000;

    // Relation field values
    localparam logic [FIELD_W-1:0] REL_FAR  = 2'b00;
    localparam logic [FIELD_W-1:0] REL_IO   = 2'b10;
    localparam logic [FIELD_W-1:0] REL_COL  = 2'b11;

    // True when a syndrome is one of the pure stuck-at/transition patterns
    function automatic logic is_static_ref(input logic [NREAD-1:0] s);
        return (s == 5'b01010) || (s == 5'b10101) || (s == 5'b00101);
    endfunction

endpackage

// File: rtl/addr_relate.sv
// addr_relate: derives the 2-bit relation field between the failing cell and
// one neighbouring address. Assumes the column is the low COL_W address bits
// and that each I/O circuit serves the columns sharing the top column bit.
module addr_relate #(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] nb_addr,
    output logic [1:0]        rel
);
    logic [COL_W-1:0] cur_col;
    logic [COL_W-1:0] nb_col;

    // Purpose: split out column parts and compare them
    always_comb begin
        cur_col = cur_addr[COL_W-1:0];
        nb_col  = nb_addr[COL_W-1:0];
        rel[1]  = (cur_col[COL_W-1] == nb_col[COL_W-1]);
        rel[0]  = (cur_col == nb_col);
    end
endmodule

// File: rtl/sig_accum.sv
// sig_accum: holds the read syndrome and the two relation fields of one
// march run. Syndrome bits are sticky until test_start; relation fields come
// from the first accepted failing read. Exposes next-state values so that a
// failure coincident with the end of the run is still classified.
module sig_accum
    import ext_sig_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               fail_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [FIELD_W-1:0] prev_rel_i,
    input  logic [FIELD_W-1:0] next_rel_i,
    output logic [NREAD-1:0]   syn_q,
    output logic [FIELD_W-1:0] prev_q,
    output logic [FIELD_W-1:0] next_q,
    output logic [NREAD-1:0]   syn_n,
    output logic [FIELD_W-1:0] prev_n,
    output logic [FIELD_W-1:0] next_n
);
    logic             cap_q;
    logic             cap_n;
    logic             accept;
    logic [NREAD-1:0] hit;

    // Purpose: decode an accepted failing read into one syndrome bit
    always_comb begin
        accept = fail_i && !start_i && (idx_i < IDX_W'(NREAD));
        hit    = '0;
        for (int i = 0; i < NREAD; i++) begin
            if (accept && (idx_i == IDX_W'(i))) hit[NREAD-1-i] = 1'b1;
        end
    end

    // Purpose: compute next syndrome, capture flag and relation fields
    always_comb begin
        if (start_i) begin
            syn_n  = '0;
            cap_n  = 1'b0;
            prev_n = REL_FAR;
            next_n = REL_FAR;
        end else begin
            syn_n  = syn_q | hit;
            cap_n  = cap_q | accept;
            prev_n = (accept && !cap_q) ? prev_rel_i : prev_q;
            next_n = (accept && !cap_q) ? next_rel_i : next_q;
        end
    end

    // Purpose: state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q  <= '0;
            cap_q  <= 1'b0;
            prev_q <= REL_FAR;
            next_q <= REL_FAR;
        end else begin
            syn_q  <= syn_n;
            cap_q  <= cap_n;
            prev_q <= prev_n;
            next_q <= next_n;
        end
    end

    // R3: syndrome bits never drop between starts
    assert_sticky_syndrome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ((syn_q & $past(syn_q)) == $past(syn_q)));

    // R4: once captured, relation fields hold until the next start
    assert_field_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && !start_i) |=> ($stable(prev_q) && $stable(next_q)));

    // R2: a same-column neighbour always shares the I/O circuit
    assert_field_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q |-> ((prev_q != 2'b01) && (next_q != 2'b01)));

    // R5: start empties the syndrome
    assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (syn_q == '0));
endmodule

// File: rtl/sig_rule.sv
// sig_rule: combinational rule set mapping an extended signature to a class
// code. Rules are tried in a fixed priority: empty, static reference,
// no sensitizing neighbour, shared coupling syndrome, then the relation-field
// cases. Assumes relation value 01 cannot occur.
module sig_rule
    import ext_sig_pkg::*;
(
    input  logic [NREAD-1:0]   syn,
    input  logic [FIELD_W-1:0] prev_f,
    input  logic [FIELD_W-1:0] next_f,
    output logic [2:0]         code
);
    logic       has_io;
    logic       has_col;
    logic       prech_only;
    class_e     cls;

    // Purpose: summarise which relation kinds are present
    always_comb begin
        has_io  = (prev_f == REL_IO)  || (next_f == REL_IO);
        has_col = (prev_f == REL_COL) || (next_f == REL_COL);
        if (prev_f == REL_COL) prech_only = ((syn & ~PREV_GROUP) == '0);
        else                   prech_only = ((syn & ~NEXT_GROUP) == '0);
    end

    // Purpose: apply the rules in priority order
    always_comb begin
        if (syn == '0)                  cls = CLS_NONE;
        else if (is_static_ref(syn))    cls = CLS_STATIC;
        else if (!has_io && !has_col)   cls = CLS_STATIC;
        else if (syn == SHARED_SYN)     cls = CLS_AMBIG;
        else if (has_io && !has_col)    cls = CLS_WDRV;
        else if (has_col && !has_io)    cls = CLS_EITHER;
        else if (prech_only)            cls = CLS_PRECH;
        else                            cls = CLS_WDRV;
        code = cls;
    end
endmodule

// File: rtl/ext_sig_classifier.sv
// ext_sig_classifier: top level. Derives relation fields for the previous and
// next address, accumulates the extended signature over one march run and
// registers a classification one cycle after test_done. Assumes one failing
// read report per cycle at most and a single-cycle test_done pulse.
module ext_sig_classifier
    import ext_sig_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_start,
    input  logic              fail_valid,
    input  logic [2:0]        fail_read_idx,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              test_done,
    output logic [8:0]        signature,
    output logic [2:0]        class_code,
    output logic              class_valid
);
    localparam int NNB = 2;   // neighbours: 0 = previous, 1 = next

    logic [ADDR_W-1:0]  nb_addr [NNB];
    logic [FIELD_W-1:0] nb_rel  [NNB];
    logic [NREAD-1:0]   syn_q, syn_n;
    logic [FIELD_W-1:0] prev_q, next_q, prev_n, next_n;
    logic [2:0]         rule_code;
    logic [2:0]         code_q;
    logic               valid_q;

    // Purpose: gather neighbour addresses for the relation generators
    always_comb begin
        nb_addr[0] = prev_addr;
        nb_addr[1] = next_addr;
    end

    for (genvar g = 0; g < NNB; g++) begin : g_rel
        addr_relate #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_rel (
            .cur_addr (cur_addr),
            .nb_addr  (nb_addr[g]),
            .rel      (nb_rel[g])
        );
    end

    sig_accum u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (test_start),
        .fail_i     (fail_valid),
        .idx_i      (fail_read_idx),
        .prev_rel_i (nb_rel[0]),
        .next_rel_i (nb_rel[1]),
        .syn_q      (syn_q),
        .prev_q     (prev_q),
        .next_q     (next_q),
        .syn_n      (syn_n),
        .prev_n     (prev_n),
        .next_n     (next_n)
    );

    sig_rule u_rule (
        .syn    (syn_n),
        .prev_f (prev_n),
        .next_f (next_n),
        .code   (rule_code)
    );

    // Purpose: register the class and the valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CLS_NONE;
            valid_q <= 1'b0;
        end else begin
            valid_q <= test_done;
            if (test_done) code_q <= rule_code;
        end
    end

    // Purpose: drive outputs
    always_comb begin
        signature   = {syn_q, prev_q, next_q};
        class_code  = code_q;
        class_valid = valid_q;
    end

    // R6: valid follows test_done by exactly one cycle
    assert_valid_follows_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> class_valid);
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_done |=> !class_valid);
    // R6: class code holds between classifications
    assert_class_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_done |=> $stable(class_code));
    // R7: only defined codes are reported, and none only for an empty syndrome
    assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> (class_code <= 3'd5));
    assert_none_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (class_valid && (class_code == 3'd0)) |-> (signature[8:4] == '0));
endmodule

// File: tb/ext_sig_classifier_bench.sv
module ext_sig_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int COL_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              test_start = 1'b0;
    logic              fail_valid = 1'b0;
    logic [2:0]        fail_read_idx = '0;
    logic [ADDR_W-1:0] cur_addr = '0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [ADDR_W-1:0] next_addr = '0;
    logic              test_done = 1'b0;
    logic [8:0]        signature;
    logic [2:0]        class_code;
    logic              class_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    ext_sig_classifier #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ext_sig_classifier (
        .clk(clk), .rst_n(rst_n), .test_start(test_start),
        .fail_valid(fail_valid), .fail_read_idx(fail_read_idx),
        .cur_addr(cur_addr), .prev_addr(prev_addr), .next_addr(next_addr),
        .test_done(test_done), .signature(signature),
        .class_code(class_code), .class_valid(class_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Relation kinds: 0 -> field 00, 1 -> field 10, 2 -> field 11
    function automatic logic [1:0] kind_field(input int k);
        return (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
    endfunction

    // Build a neighbour address of the given relation kind (R2 encoding)
    function automatic logic [ADDR_W-1:0] nb_of(input logic [ADDR_W-1:0] c, input int k);
        logic [ADDR_W-1:0] a;
        a = c;
        if (k == 0)      a[COL_W-1] = ~c[COL_W-1];
        else if (k == 1) a[0] = ~c[0];
        else             a[ADDR_W-1:COL_W] = c[ADDR_W-1:COL_W] + 1'b1;
        return a;
    endfunction

    // Expected class from the rule list (R7..R11)
    function automatic int exp_class(input logic [4:0] s, input logic [1:0] pf, input logic [1:0] nf);
        logic hio, hcol, ponly;
        hio  = (pf == 2'b10) || (nf == 2'b10);
        hcol = (pf == 2'b11) || (nf == 2'b11);
        if (pf == 2'b11) ponly = ((s & ~5'b11001) == 0);
        else             ponly = ((s & ~5'b00110) == 0);
        if (s == 0) return 0;
        if (s == 5'b01010 || s == 5'b10101 || s == 5'b00101) return 1;
        if (!hio && !hcol) return 1;
        if (s == 5'b10000) return 5;
        if (hio && !hcol) return 2;
        if (hcol && !hio) return 4;
        return ponly ? 3 : 2;
    endfunction

    task automatic pulse_start();
        test_start = 1'b1;
        @(negedge clk);
        test_start = 1'b0;
    endtask

    task automatic set_fail(input int idx, input logic [ADDR_W-1:0] c, input int kp, input int kn);
        fail_valid    = 1'b1;
        fail_read_idx = 3'(idx);
        cur_addr      = c;
        prev_addr     = nb_of(c, kp);
        next_addr     = nb_of(c, kn);
    endtask

    task automatic do_fail(input int idx, input logic [ADDR_W-1:0] c, input int kp, input int kn);
        set_fail(idx, c, kp, kn);
        @(negedge clk);
        fail_valid = 1'b0;
    endtask

    task automatic do_done();
        test_done = 1'b1;
        @(negedge clk);
        test_done = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] c;
        int run;
        run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 signature", int'(signature), 0);
        chk("R1 class_code", int'(class_code), 0);
        chk("R1 class_valid", int'(class_valid), 0);

        // R3: out-of-range indexes ignored
        pulse_start();
        for (int i = 5; i < 8; i++) do_fail(i, 6'b001010, 1, 1);
        chk("R3 idx>4 ignored", int'(signature), 0);
        do_done();
        chk("R3 idx>4 class none", int'(class_code), 0);

        // R5: failure together with start is dropped
        do_fail(1, 6'b010011, 2, 2);
        chk("R5 pre-start fail", int'(signature), 9'b010001111);
        test_start = 1'b1;
        set_fail(0, 6'b010011, 1, 1);
        @(negedge clk);
        test_start = 1'b0;
        fail_valid = 1'b0;
        chk("R5 start clears and drops", int'(signature), 0);

        // R6: failure together with done is classified; class held afterwards
        test_done = 1'b1;
        set_fail(0, 6'b100101, 1, 1);
        @(negedge clk);
        test_done = 1'b0;
        fail_valid = 1'b0;
        chk("R6 valid pulse", int'(class_valid), 1);
        chk("R6 coincident fail class (R9)", int'(class_code), 5);
        chk("R6 coincident fail signature", int'(signature), 9'b100001010);
        @(negedge clk);
        chk("R6 valid drops", int'(class_valid), 0);
        chk("R6 class held", int'(class_code), 5);

        // R4: second failure with another relation keeps the first fields
        pulse_start();
        do_fail(2, 6'b000110, 2, 1);
        do_fail(3, 6'b000110, 0, 0);
        chk("R4 first fields kept", int'(signature), 9'b001101110);

        // Sweep: every syndrome x every reachable field pair (R2,R3,R4,R7-R11)
        for (int s = 0; s < 32; s++) begin
            for (int kp = 0; kp < 3; kp++) begin
                for (int kn = 0; kn < 3; kn++) begin
                    bit first;
                    logic [1:0] pf, nf;
                    int ec;
                    first = 1;
                    c = 6'(run * 5 + 3);
                    run++;
                    pulse_start();
                    for (int i = 0; i < 5; i++) begin
                        if (s[4-i]) begin
                            if (first) do_fail(i, c, kp, kn);
                            else       do_fail(i, c, (kp + 1) % 3, (kn + 2) % 3);
                            first = 0;
                        end
                    end
                    pf = (s == 0) ? 2'b00 : kind_field(kp);
                    nf = (s == 0) ? 2'b00 : kind_field(kn);
                    ec = exp_class(5'(s), pf, nf);
                    do_done();
                    chk("R3/R4 signature", int'(signature), int'({5'(s), pf, nf}));
                    chk("R6 valid", int'(class_valid), 1);
                    if (s == 0)                    chk("R7 empty", int'(class_code), ec);
                    else if (ec == 1)              chk("R7/R8 static", int'(class_code), ec);
                    else if (ec == 5)              chk("R9 ambiguous", int'(class_code), ec);
                    else if (pf != 2'b00 && nf != 2'b00 && pf != nf)
                                                   chk("R11 mixed", int'(class_code), ec);
                    else                           chk("R10 relation", int'(class_code), ec);
                end
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule